// File: doc/BRIEF.md
# MMC Boot Read Controller

This block performs the host side of an MMC boot read on a single data line. After a start request it pulls the command line low and keeps it there. While the line is low the device streams boot data on DAT0. If acknowledge checking is enabled, the controller first expects a short acknowledge frame. It then receives a programmed number of fixed-size blocks and checks the CRC of each block. The data is handed to the consumer one byte at a time with a single-cycle ready flag.

The serial line is sampled only on cycles where the bit-clock enable is high, so a bus-clock generator outside the block sets the bit rate. A watchdog limit, counted in bit ticks, covers both the wait for the acknowledge and the wait for each block's start bit. The stream is closed by a boot-end request. That request releases the command line and returns the block to idle from any state.

Top module: `boot_rd_ctrl`

## Requirements
- R1: After reset, cmd_o is 1 (released), and rxrdy_o, done_o and err_o are 0.
- R2: A start_i pulse while idle drives cmd_o to 0 from the next cycle. cmd_o stays 0 until boot_end_i is sampled high. boot_end_i returns the block to idle in the next cycle: cmd_o becomes 1, and done_o and err_o are cleared. boot_end_i takes priority over every other input.
- R3: DAT0 is sampled only on cycles with clk_en_i high. The DAT0 value on any other cycle has no effect.
- R4: With ack_en_i high at start, the controller waits for a 0 start bit. It then expects the bits 0, 1, 0, 1 on the next four ticks. The first mismatching bit sets err_o in the next cycle.
- R5: A block is framed as a 0 start bit, then BLK_BYTES data bytes sent MSB first, then 16 CRC bits sent MSB first, then a 1 end bit.
- R6: Each received byte appears on data_o with rxrdy_o high for exactly one cycle, the cycle after the tick that carried its last bit. Bytes are delivered in arrival order.
- R7: The CRC uses polynomial x^16+x^12+x^5+1 with a zero initial value, computed over the block's data bytes. A CRC mismatch or a 0 end bit sets err_o in the cycle after the end-bit tick.
- R8: In the acknowledge wait or the block-start wait, err_o is set after the timeout_i-th consecutive tick with DAT0 high. The count restarts on each entry into a wait.
- R9: done_o rises in the cycle after the end bit of block number blk_cnt_i. With blk_cnt_i = 0, done_o rises right after start, or right after the acknowledge when it is enabled. done_o holds until boot_end_i.
- R10: Once err_o or done_o is set, further DAT0 activity delivers no byte, and cmd_o stays 0 until boot_end_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a boot read (accepted while idle) |
| ack_en_i | input | 1 | Expect acknowledge frame before data |
| blk_cnt_i | input | CNT_W | Number of blocks to receive |
| timeout_i | input | TO_W | Wait limit in bit ticks |
| boot_end_i | input | 1 | End boot stream, release command line |
| clk_en_i | input | 1 | Bit tick: sample DAT0 this cycle |
| dat0_i | input | 1 | Serial data line |
| cmd_o | output | 1 | Command line level (0 = held low) |
| data_o | output | 8 | Received byte |
| rxrdy_o | output | 1 | data_o valid, one-cycle pulse |
| done_o | output | 1 | All programmed blocks received |
| err_o | output | 1 | Acknowledge, CRC, end-bit or timeout failure |

## Verification
The first clean transfer enables the acknowledge, uses two blocks and a tick on every cycle. It confirms byte order and that a new block's CRC does not depend on the previous block. A second transfer ticks every third cycle and drives the inverted bit on the idle cycles, so any sampling outside a tick shows up as corrupt data. Failing transfers cover a flipped CRC bit, a wrong acknowledge bit, and timeouts in both wait states. Together they show where each failure is detected and that no byte leaks out after an error. Zero-block runs, with and without the acknowledge, separate the immediate-done path from the normal block loop.

// File: rtl/boot_rd_pkg.sv
package boot_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK_WAIT, ST_ACK_BITS, ST_BLK_WAIT,
    ST_DATA, ST_CRC, ST_END, ST_DONE, ST_ERR
  } boot_st_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/boot_crc16.sv
module boot_crc16
  import boot_rd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb    = bit_i ^ crc_q[15];
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end
endmodule

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // expires on the tick that would make the count reach the limit
  assign expire_o = inc_i && (({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/boot_deser.sv
module boot_deser #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic         last_o,
  output logic [W-1:0] byte_o,
  output logic         vld_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;
  logic [W-1:0]  byte_q;
  logic          vld_q;

  assign last_o = en_i && (cnt_q == CW'(W-1));
  assign byte_o = byte_q;
  assign vld_o  = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= last_o;
      if (last_o) byte_q <= {sh_q, bit_i};
      if (clr_i) begin
        cnt_q <= '0;
      end else if (en_i) begin
        cnt_q <= last_o ? '0 : cnt_q + CW'(1);
        sh_q  <= {sh_q[W-3:0], bit_i};
      end
    end
  end

  p_vld_needs_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(en_i));
endmodule

// File: rtl/boot_rd_ctrl.sv
module boot_rd_ctrl
  import boot_rd_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 8,
  parameter int TO_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ack_en_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic             boot_end_i,
  input  logic             clk_en_i,
  input  logic             dat0_i,
  output logic             cmd_o,
  output logic [7:0]       data_o,
  output logic             rxrdy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int BYTE_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;

  boot_st_e          state_q, state_d;
  logic [CNT_W-1:0]  left_q;
  logic [BYTE_W-1:0] byte_q;
  logic [3:0]        bit_q;

  logic        in_wait, to_inc, to_exp;
  logic        ds_en, ds_last;
  logic        crc_en, crc_clr;
  logic [15:0] crc_val;
  logic        end_ok;

  assign in_wait = (state_q == ST_ACK_WAIT) || (state_q == ST_BLK_WAIT);
  assign to_inc  = in_wait && clk_en_i && dat0_i;
  assign ds_en   = clk_en_i && (state_q == ST_DATA);
  assign crc_en  = clk_en_i && ((state_q == ST_DATA) || (state_q == ST_CRC));
  assign crc_clr = (state_q == ST_BLK_WAIT);
  assign end_ok  = dat0_i && (crc_val == 16'h0000);

  boot_timer #(.W(TO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!in_wait),
    .inc_i   (to_inc),
    .limit_i (timeout_i),
    .expire_o(to_exp)
  );

  boot_deser #(.W(8)) u_deser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_DATA),
    .en_i  (ds_en),
    .bit_i (dat0_i),
    .last_o(ds_last),
    .byte_o(data_o),
    .vld_o (rxrdy_o)
  );

  boot_crc16 u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .bit_i (dat0_i),
    .crc_o (crc_val)
  );

  always_comb begin
    state_d = state_q;
    if (boot_end_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (ack_en_i)              state_d = ST_ACK_WAIT;
          else if (blk_cnt_i == '0)  state_d = ST_DONE;
          else                       state_d = ST_BLK_WAIT;
        end
        ST_ACK_WAIT: if (clk_en_i) begin
          if (!dat0_i)     state_d = ST_ACK_BITS;
          else if (to_exp) state_d = ST_ERR;
        end
        ST_ACK_BITS: if (clk_en_i) begin
          // expected sequence after start bit: 0,1,0,1 == bit index LSB
          if (dat0_i != bit_q[0]) state_d = ST_ERR;
          else if (bit_q == 4'd3) state_d = (left_q == '0) ? ST_DONE : ST_BLK_WAIT;
        end
        ST_BLK_WAIT: if (clk_en_i) begin
          if (!dat0_i)     state_d = ST_DATA;
          else if (to_exp) state_d = ST_ERR;
        end
        ST_DATA: if (ds_last && (byte_q == BYTE_W'(BLK_BYTES-1))) state_d = ST_CRC;
        ST_CRC:  if (clk_en_i && (bit_q == 4'd15)) state_d = ST_END;
        ST_END: if (clk_en_i) begin
          if (!end_ok)                     state_d = ST_ERR;
          else if (left_q == CNT_W'(1))    state_d = ST_DONE;
          else                             state_d = ST_BLK_WAIT;
        end
        ST_DONE: state_d = ST_DONE;
        ST_ERR:  state_d = ST_ERR;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i && !boot_end_i) left_q <= blk_cnt_i;
      else if (state_q == ST_END && clk_en_i && end_ok && !boot_end_i) left_q <= left_q - CNT_W'(1);

      if (state_q != ST_DATA) byte_q <= '0;
      else if (ds_last)       byte_q <= byte_q + BYTE_W'(1);

      if (state_d != state_q) bit_q <= '0;
      else if (clk_en_i && (state_q == ST_ACK_BITS || state_q == ST_CRC)) bit_q <= bit_q + 4'd1;
    end
  end

  assign cmd_o  = (state_q == ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o && start_i && !boot_end_i) |=> !cmd_o);
  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_o && !boot_end_i) |=> !cmd_o);
  p_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_end_i |=> (cmd_o && !done_o && !err_o));
  p_one_shot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxrdy_o |=> !rxrdy_o);
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !boot_end_i) |=> done_o);
  p_no_rx_in_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rxrdy_o);
endmodule

// File: tb/sim_boot_rd_ctrl.sv
module sim_boot_rd_ctrl;
  localparam int BLK_BYTES = 512;
  localparam int CNT_W     = 8;
  localparam int TO_W      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ack_en = 1'b0, bend = 1'b0, en = 1'b0, dat = 1'b1;
  logic [CNT_W-1:0] blk_cnt = '0;
  logic [TO_W-1:0]  tmo = 16'd20;
  logic cmd, rxrdy, done, err;
  logic [7:0] data;

  int checks = 0, errors = 0, rx_count = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  boot_rd_ctrl #(.BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W), .TO_W(TO_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ack_en_i(ack_en),
    .blk_cnt_i(blk_cnt), .timeout_i(tmo), .boot_end_i(bend),
    .clk_en_i(en), .dat0_i(dat), .cmd_o(cmd), .data_o(data),
    .rxrdy_o(rxrdy), .done_o(done), .err_o(err));

  // reference model: 0 idle,1 ack wait,2 ack bits,3 blk wait,4 data,5 crc,6 end,7 done,8 err
  int m_st = 0, m_bits = 0, m_left = 0, m_to = 0;
  logic [7:0]  m_cur;
  logic [15:0] m_crc;
  logic [7:0]  m_q[$];
  logic        e_rx = 1'b0;
  logic [7:0]  e_data = 8'h00;

  function automatic logic [15:0] crc_of(input logic [7:0] q[$]);
    logic [15:0] c = 16'h0000;
    foreach (q[i])
      for (int k = 7; k >= 0; k--)
        c = (c[15] ^ q[i][k]) ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(input logic s, input logic be, input logic t, input logic b);
    e_rx = 1'b0;
    if (be) m_st = 0;
    else case (m_st)
      0: if (s) begin
           m_left = blk_cnt; m_to = 0;
           m_st = ack_en ? 1 : (blk_cnt == 0 ? 7 : 3);
         end
      1, 3: if (t) begin
           if (!b) begin
             m_bits = 0; m_q.delete();
             m_st = (m_st == 1) ? 2 : 4;
           end else begin
             m_to++;
             if (m_to >= tmo) m_st = 8;
           end
         end
      2: if (t) begin
           if (b != ((m_bits == 1) || (m_bits == 3))) m_st = 8;
           else if (m_bits == 3) begin m_to = 0; m_st = (m_left == 0) ? 7 : 3; end
           else m_bits++;
         end
      4: if (t) begin
           m_cur = {m_cur[6:0], b}; m_bits++;
           if (m_bits == 8) begin
             m_q.push_back(m_cur); e_rx = 1'b1; e_data = m_cur; m_bits = 0;
             if (m_q.size() == BLK_BYTES) begin m_st = 5; m_crc = 16'h0; end
           end
         end
      5: if (t) begin
           m_crc = {m_crc[14:0], b}; m_bits++;
           if (m_bits == 16) m_st = 6;
         end
      6: if (t) begin
           if (b && (m_crc == crc_of(m_q))) begin
             m_left--; m_to = 0; m_st = (m_left == 0) ? 7 : 3;
           end else m_st = 8;
         end
      default: ;
    endcase
  endtask

  task automatic cyc(input logic s, input logic be, input logic t, input logic b);
    @(negedge clk);
    start = s; bend = be; en = t; dat = b;
    @(posedge clk);
    model_step(s, be, t, b);
    #1;
    if (rxrdy) rx_count++;
    chk(cmd === (m_st == 0), "R2", "cmd_o", int'(cmd), int'(m_st == 0));
    chk(rxrdy === e_rx, "R6", "rxrdy_o", int'(rxrdy), int'(e_rx));
    if (e_rx) chk(data === e_data, "R5", "data_o", int'(data), int'(e_data));
    chk(done === (m_st == 7), "R9", "done_o", int'(done), int'(m_st == 7));
    chk(err === (m_st == 8), "R7", "err_o", int'(err), int'(m_st == 8));
  endtask

  task automatic tick_bit(input logic b, input int gap);
    repeat (gap) cyc(1'b0, 1'b0, 1'b0, ~b);
    cyc(1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic send_block(input int seed, input int gap, input bit bad);
    logic [7:0] q[$];
    logic [15:0] c;
    for (int i = 0; i < BLK_BYTES; i++) q.push_back(8'((i * 7 + seed * 13) ^ (i >> 3)));
    c = crc_of(q);
    if (bad) c[0] = ~c[0];
    tick_bit(1'b0, gap);
    foreach (q[i]) for (int k = 7; k >= 0; k--) tick_bit(q[i][k], gap);
    for (int k = 15; k >= 0; k--) tick_bit(c[k], gap);
    tick_bit(1'b1, gap);
  endtask

  task automatic begin_boot(input logic a, input int n, input int t);
    @(negedge clk);
    ack_en = a; blk_cnt = CNT_W'(n); tmo = TO_W'(t); rx_count = 0;
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic end_boot();
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    chk(cmd === 1'b1 && !done && !err, "R2", "release after boot end", int'({cmd, done, err}), 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(cmd === 1'b1, "R1", "reset cmd_o", int'(cmd), 1);
    chk(!rxrdy && !done && !err, "R1", "reset flags", int'({rxrdy, done, err}), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);

    // two blocks with acknowledge, tick every cycle
    begin_boot(1'b1, 2, 20);
    repeat (3) tick_bit(1'b1, 0);
    tick_bit(1'b0, 0); tick_bit(1'b0, 0); tick_bit(1'b1, 0); tick_bit(1'b0, 0); tick_bit(1'b1, 0);
    repeat (2) tick_bit(1'b1, 0);
    send_block(1, 0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b1); // start while busy has no effect (R2)
    tick_bit(1'b1, 0);
    send_block(2, 0, 1'b0);
    chk(done === 1'b1, "R9", "done after last block", int'(done), 1);
    chk(rx_count == 2 * BLK_BYTES, "R6", "byte count", rx_count, 2 * BLK_BYTES);
    repeat (20) tick_bit(1'b0, 0);
    chk(rx_count == 2 * BLK_BYTES && cmd === 1'b0, "R10", "quiet after done", rx_count, 2 * BLK_BYTES);
    end_boot();

    // no acknowledge, sparse ticks, inverted value on idle cycles
    begin_boot(1'b0, 1, 20);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    send_block(3, 2, 1'b0);
    chk(done === 1'b1 && rx_count == BLK_BYTES, "R3", "gated sampling", rx_count, BLK_BYTES);
    end_boot();

    // CRC failure on first of two blocks
    begin_boot(1'b0, 2, 20);
    send_block(4, 0, 1'b1);
    chk(err === 1'b1, "R7", "crc mismatch error", int'(err), 1);
    send_block(5, 0, 1'b0);
    chk(rx_count == BLK_BYTES && cmd === 1'b0, "R10", "no bytes after error", rx_count, BLK_BYTES);
    end_boot();

    // wrong acknowledge pattern
    begin_boot(1'b1, 1, 20);
    tick_bit(1'b0, 0); tick_bit(1'b0, 0); tick_bit(1'b1, 0);
    chk(err === 1'b0, "R4", "ack in progress", int'(err), 0);
    tick_bit(1'b1, 0);
    chk(err === 1'b1, "R4", "ack mismatch error", int'(err), 1);
    end_boot();

    // acknowledge timeout
    begin_boot(1'b1, 1, 5);
    repeat (4) tick_bit(1'b1, 1);
    chk(err === 1'b0, "R8", "before ack timeout", int'(err), 0);
    tick_bit(1'b1, 0);
    chk(err === 1'b1, "R8", "ack timeout", int'(err), 1);
    end_boot();

    // block start timeout, no acknowledge
    begin_boot(1'b0, 1, 3);
    repeat (2) tick_bit(1'b1, 0);
    chk(err === 1'b0, "R8", "before block timeout", int'(err), 0);
    tick_bit(1'b1, 0);
    chk(err === 1'b1, "R8", "block start timeout", int'(err), 1);
    end_boot();

    // zero blocks, with and without acknowledge
    begin_boot(1'b0, 0, 5);
    chk(done === 1'b1, "R9", "zero blocks no ack", int'(done), 1);
    end_boot();
    begin_boot(1'b1, 0, 5);
    tick_bit(1'b0, 0); tick_bit(1'b0, 0); tick_bit(1'b1, 0); tick_bit(1'b0, 0); tick_bit(1'b1, 0);
    chk(done === 1'b1, "R9", "zero blocks after ack", int'(done), 1);
    end_boot();

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule